// File: doc/BRIEF.md
# Addressed Serial Code Latch for a Multi-Drop Current DAC

This block is the digital front end of a current-output DAC that shares a three-wire serial bus with other devices of its kind. A host drives an active-low select, a serial clock and a data line. The block brings all three into its own system clock domain and shifts data bits in on each rising serial clock edge. When the select is released, it decides whether the frame belongs to it. A 16-bit frame carries one leading bit that must be zero, then a 3-bit device address, then a 12-bit code. If the leading bit is zero and the address equals the strap inputs, the code moves into a holding latch that feeds the converter.

An active-low reset clears the code at once, without waiting for a clock. An active-low standby input turns off the output enable and blocks every load. When standby is released, the code held before standby is used again. Several devices with equal straps update together from a single frame. The system clock must run at least four times faster than the serial clock.

Top module: `sdac_front`

## Requirements
- R1: Each data bit is taken on a rising serial clock edge while select is low, first bit in is the most significant. Frame bit 15 is the leading bit, bits 14..12 are the address and bits 11..0 are the code.
- R2: On the rising edge of select, a frame with leading bit 0 and address equal to `addr_strap` replaces `code_q` with its bits 11..0 within 6 system clocks.
- R3: A frame whose leading bit is 1, or whose address differs from `addr_strap`, is dropped. `code_q` keeps its value and no load strobe is issued.
- R4: When more than 16 bits are clocked in during one select window, only the last 16 bits clocked in are evaluated.
- R5: When fewer than 16 bits are clocked in during one select window, the frame is ignored.
- R6: While `rst_n` is low, `code_q` is 0x000, `out_en` is low and `load_pulse` is low, with the clear taking effect asynchronously. Bits clocked while reset is held never cause a load.
- R7: While `stby_n` is low, `out_en` is low and no frame is loaded. After `stby_n` returns high, `out_en` is high and `code_q` holds the code it had before standby.
- R8: `load_pulse` is high for exactly one system clock for each update of `code_q` and is low at all other times.
- R9: A falling edge of select clears the bit count and the shift register. Bits from an earlier, unfinished window therefore never count toward the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_n | input | 1 | Active-low standby |
| addr_strap | input | 3 | Strapped device address |
| ser_cs_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock |
| ser_dat | input | 1 | Serial data |
| code_q | output | 12 | Latched DAC code |
| out_en | output | 1 | Output stage enable |
| load_pulse | output | 1 | One-cycle strobe on each code update |

## Verification
The bench builds the block with its default widths: a 3-bit address, a 12-bit code and two synchroniser stages. This keeps the address space small enough to sweep completely. All eight strap values are crossed with all sixteen leading-bit and address combinations, so every match and every mismatch of R2 and R3 is exercised, with codes that include zero and full scale. Short, over-long and split frames, reset held during a frame, and standby held during a frame are each driven with expected codes and strobe counts worked out arithmetically.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
   // value the leading frame bit must carry for a frame to be accepted
   localparam logic LEAD_OK = 1'b0;

   function automatic int frame_bits(input int addr_w, input int code_w);
      return 1 + addr_w + code_w;
   endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sdac_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stg
      logic [W-1:0] r;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= RST_VAL;
            else        r <= g_stg[i-1].r;
      end
   end

   assign q = g_stg[STAGES-1].r;
endmodule

// File: rtl/sdac_rx.sv
module sdac_rx #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_s,
   input  logic               sclk_s,
   input  logic               dat_s,
   output logic [FRAME_W-1:0] frame_q,
   output logic               frame_full,
   output logic               cs_rise
);
   localparam int CNT_W = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FRAME_W);

   logic             cs_d, sclk_d;
   logic [CNT_W-1:0] bit_cnt;
   logic             cs_fall, sclk_rise;

   assign cs_fall   = cs_d & ~cs_s;
   assign cs_rise   = ~cs_d & cs_s;
   assign sclk_rise = sclk_s & ~sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d   <= 1'b1;
         sclk_d <= 1'b0;
      end else begin
         cs_d   <= cs_s;
         sclk_d <= sclk_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
         bit_cnt <= '0;
      end else if (cs_fall) begin
         frame_q <= '0;
         bit_cnt <= '0;
      end else if (!cs_s && sclk_rise) begin
         frame_q <= {frame_q[FRAME_W-2:0], dat_s};
         if (bit_cnt != CNT_TOP) bit_cnt <= bit_cnt + 1'b1;
      end
   end

   assign frame_full = (bit_cnt == CNT_TOP);
endmodule

// File: rtl/sdac_latch.sv
module sdac_latch
   import sdac_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int CODE_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                cs_rise,
   input  logic                frame_full,
   input  logic [frame_bits(ADDR_W, CODE_W)-1:0] frame,
   input  logic [ADDR_W-1:0]   strap,
   output logic [CODE_W-1:0]   code_q,
   output logic                load_pulse
);
   localparam int FW = frame_bits(ADDR_W, CODE_W);

   logic lead_ok, addr_ok, take;

   assign lead_ok = (frame[FW-1] == LEAD_OK);
   assign addr_ok = (frame[FW-2 -: ADDR_W] == strap);
   assign take    = cs_rise & frame_full & enable & lead_ok & addr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q     <= '0;
         load_pulse <= 1'b0;
      end else begin
         load_pulse <= take;
         if (take) code_q <= frame[CODE_W-1:0];
      end
   end
endmodule

// File: rtl/sdac_front.sv
module sdac_front
   import sdac_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int CODE_W = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stby_n,
   input  logic [ADDR_W-1:0] addr_strap,
   input  logic              ser_cs_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   output logic [CODE_W-1:0] code_q,
   output logic              out_en,
   output logic              load_pulse
);
   localparam int FW = frame_bits(ADDR_W, CODE_W);

   if (ADDR_W < 1 || CODE_W < 1) begin : g_bad_width
      $error("sdac_front: ADDR_W and CODE_W must be positive");
   end

   logic [3:0]    raw_in, syn_q;
   logic          stby_s, cs_s, sclk_s, dat_s;
   logic [FW-1:0] frame;
   logic          frame_full, cs_rise;

   assign raw_in = {stby_n, ser_cs_n, ser_clk, ser_dat};

   sdac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_q)
   );

   assign {stby_s, cs_s, sclk_s, dat_s} = syn_q;
   assign out_en = stby_s;

   sdac_rx #(.FRAME_W(FW)) u_rx (
      .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_s(sclk_s), .dat_s(dat_s),
      .frame_q(frame), .frame_full(frame_full), .cs_rise(cs_rise)
   );

   sdac_latch #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .enable(stby_s), .cs_rise(cs_rise),
      .frame_full(frame_full), .frame(frame), .strap(addr_strap),
      .code_q(code_q), .load_pulse(load_pulse)
   );
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
   parameter int CODE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W-1:0] code_q,
   input logic              out_en,
   input logic              load_pulse
);
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      load_pulse |=> !load_pulse) else $error("load strobe longer than one cycle"); // R8

   AST_CODE_MOVES_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_pulse |-> $stable(code_q)) else $error("code changed without strobe"); // R8

   AST_LOAD_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      load_pulse |-> $past(out_en)) else $error("load while in standby"); // R7

   always @(posedge clk)
      if (!rst_n)
         AST_RESET_CLEAR: assert (code_q == '0 && !out_en && !load_pulse)
            else $error("outputs not clear in reset"); // R6
endmodule

bind sdac_front sdac_front_chk #(.CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .code_q(code_q), .out_en(out_en), .load_pulse(load_pulse)
);

// File: tb/sdac_front_tb.sv
module sdac_front_tb;
   localparam int CYC = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stby_n = 1'b1;
   logic [2:0]  addr_strap = 3'd0;
   logic        ser_cs_n = 1'b1;
   logic        ser_clk = 1'b0;
   logic        ser_dat = 1'b0;
   logic [11:0] code_q;
   logic        out_en;
   logic        load_pulse;

   int n_chk = 0, n_bad = 0, pulses = 0;
   logic prev_pulse = 1'b0;
   logic [11:0] exp_code = 12'h000;
   int exp_pulses = 0;

   always #(CYC/2) clk = ~clk;

   sdac_front u_dut (
      .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .addr_strap(addr_strap),
      .ser_cs_n(ser_cs_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .code_q(code_q), .out_en(out_en), .load_pulse(load_pulse)
   );

   always @(negedge clk) begin
      if (rst_n && load_pulse) pulses++;
      if (rst_n && load_pulse && prev_pulse) begin
         n_chk++; n_bad++;
         $display("FAIL R8 strobe held two cycles act=1 exp=0");
      end
      prev_pulse = load_pulse;
   end

   task automatic report();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CYC * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      report();
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // select low, shift n bits (MSB of the n first), select high
   task automatic send_bits(input logic [31:0] v, input int n);
      ser_cs_n = 1'b0;
      wait_clk(4);
      for (int i = n - 1; i >= 0; i--) begin
         ser_dat = v[i];
         wait_clk(3);
         ser_clk = 1'b1;
         wait_clk(3);
         ser_clk = 1'b0;
      end
      wait_clk(3);
      ser_cs_n = 1'b1;
      wait_clk(8);
   endtask

   task automatic check_state(input string req);
      check({req, " code"}, int'(code_q), int'(exp_code));
      check({req, " strobes"}, pulses, exp_pulses);
   endtask

   initial begin
      wait_clk(3);
      check("R6 reset code", int'(code_q), 0);
      check("R6 reset out_en", int'(out_en), 0);
      check("R6 reset strobe", int'(load_pulse), 0);
      rst_n = 1'b1;
      wait_clk(5);
      check("R7 out_en active", int'(out_en), 1);

      // R1 R2 R3: all straps crossed with all lead/address nibbles
      for (int s = 0; s < 8; s++) begin
         addr_strap = 3'(s);
         wait_clk(2);
         for (int f = 0; f < 16; f++) begin
            logic [11:0] d;
            d = 12'(((s * 16 + f) * 37 + 5));
            if (f == 3) d = 12'hFFF;
            if (f == 5) d = 12'h000;
            send_bits({16'h0, 4'(f), d}, 16);
            if (f < 8 && f == s) begin
               exp_code = d;
               exp_pulses++;
               check_state("R2 matching frame");
            end else begin
               check_state("R3 foreign or bad lead");
            end
         end
      end

      addr_strap = 3'd5;
      wait_clk(2);
      // R4: 20 bits, the first four junk, last sixteen a valid frame
      send_bits({12'h0, 4'hF, 1'b0, 3'd5, 12'hA5C}, 20);
      exp_code = 12'hA5C; exp_pulses++;
      check_state("R4 long frame keeps last bits");
      // R4: last sixteen carry the wrong address although the first ones match
      send_bits({12'h0, 1'b0, 3'd5, 1'b0, 3'd2, 12'h123}, 20);
      check_state("R4 long frame last bits foreign");

      // R5: 15 bits ignored
      send_bits({17'h0, 3'd5, 12'h777}, 15);
      check_state("R5 short frame ignored");

      // R9: 8 bits, release, then 12 bits; no carry-over between windows
      send_bits({24'h0, 8'h5A}, 8);
      send_bits({20'h0, 12'h3C3}, 12);
      check_state("R9 split windows ignored");
      send_bits({16'h0, 1'b0, 3'd5, 12'h0F0}, 16);
      exp_code = 12'h0F0; exp_pulses++;
      check_state("R9 next full frame loads");

      // R7: standby blocks load and drops enable, restore keeps code
      stby_n = 1'b0;
      wait_clk(5);
      check("R7 standby out_en", int'(out_en), 0);
      send_bits({16'h0, 1'b0, 3'd5, 12'h999}, 16);
      check_state("R7 no load in standby");
      stby_n = 1'b1;
      wait_clk(5);
      check("R7 restore out_en", int'(out_en), 1);
      check_state("R7 restore code");

      // R6: frame clocked while reset held does not load; code cleared
      rst_n = 1'b0;
      wait_clk(2);
      check("R6 async clear", int'(code_q), 0);
      send_bits({16'h0, 1'b0, 3'd5, 12'h444}, 16);
      rst_n = 1'b1;
      wait_clk(8);
      exp_code = 12'h000;
      check_state("R6 no load from reset frame");
      send_bits({16'h0, 1'b0, 3'd5, 12'h801}, 16);
      exp_code = 12'h801; exp_pulses++;
      check_state("R6 load after reset release");

      report();
   end
endmodule